// File: doc/BRIEF.md
# Oversampled serial receiver with two-word receive queue

This block takes a single asynchronous serial line and rebuilds characters from it. A tick arriving at sixteen times the bit rate drives the sampling. Each character is one low start bit, then 8 or 9 data bits sent least significant bit first, then one stop bit. The finished word goes into a small receive queue, two entries deep by default. Each entry keeps the word together with its own framing-error flag. The host sees the oldest entry on the read port. A one-cycle read strobe removes that entry, and the port then shows the next one.

A data-available flag and an interrupt output, gated by an enable input, tell the host that words are waiting. A character can finish while the queue is full. When that happens the block raises a sticky overrun flag and throws the character away. It then accepts no more words until the receive enable is dropped and raised again. Dropping the enable also empties the queue and returns the receiver to idle.

Top module: `srx_top`

## Requirements
- R1: Reception happens only while `rx_en` is 1. A character sent on `rxd` while `rx_en` is 0 leaves no word in the queue.
- R2: A start is recognised only when a falling edge is followed by a low line at oversample 8 of the start bit. A low pulse shorter than half a bit is a false start and produces no word.
- R3: Data bits arrive LSb first. Each bit is the majority of oversamples 7, 8 and 9 of its bit period. When `nine_bit` is 0 at the start bit, 8 bits are taken and `rd_data[8]` reads 0. When it is 1, 9 bits are taken and `rd_data[8]` is the 9th bit.
- R4: `rd_ferr` for an entry is 1 exactly when that character's stop bit was sampled as 0. The word bits are still delivered.
- R5: The queue holds two words in arrival order. `rd_data` and `rd_ferr` show the oldest entry. A `rd_stb` pulse while data is available removes it, and the next entry's word and flag appear on the next cycle.
- R6: `data_avail` is 1 while at least one word is queued. `irq` is 1 exactly when `data_avail` and `irq_en` are both 1. After reset both are 0, and so is `overrun`.
- R7: If both entries are full when a character's stop bit is sampled, `overrun` becomes 1 and that character is discarded. The two queued words are kept unchanged.
- R8: While `overrun` is 1, no new word enters the queue. `overrun` remains 1 until `rx_en` goes to 0.
- R9: Driving `rx_en` to 0 for one cycle empties the queue, clears `overrun` and returns the receiver to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Receive enable; low flushes and clears overrun |
| nine_bit | input | 1 | 1 selects 9 data bits per character |
| irq_en | input | 1 | Interrupt enable |
| rxd | input | 1 | Serial receive line, idle high |
| rd_stb | input | 1 | Read strobe, pops the oldest entry |
| rd_data | output | 9 | Oldest entry word; bit 8 is the 9th data bit |
| rd_ferr | output | 1 | Framing-error flag of the oldest entry |
| data_avail | output | 1 | At least one word queued |
| irq | output | 1 | data_avail gated by irq_en |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Fixed words tell the two data widths apart. They include a word whose bit 8 is set but is sent as an 8-bit character, so the 9th bit must be masked. Back-to-back characters with different stop-bit values show whether each queue entry keeps its own framing flag through a pop. A run of three and then four characters with no reads separates overrun from normal filling, and shows that reception stays frozen until the enable is toggled. Short low pulses, characters sent while disabled, and a seeded random mix of widths, stop values, reads and enable toggles are each checked against a queue model kept in the bench.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '1;
            else        sr_q <= {sr_q[STAGES-2:0], d};
         end
         assign q = sr_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int DW  = 8,
   parameter int OVS = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        tick,
   input  logic        nine,
   input  logic        rxd,
   output logic        done,
   output logic [DW:0] word,
   output logic        ferr
);
   localparam int CW  = $clog2(OVS);
   localparam int MID = OVS / 2;
   localparam int BW  = $clog2(DW + 1);

   rx_state_e      st_q;
   logic [CW-1:0]  cnt_q;
   logic [BW-1:0]  bidx_q;
   logic [BW-1:0]  last;
   logic [DW:0]    shreg_q;
   logic           prev_q, va_q, vb_q, nine_q, done_q, ferr_q;

   assign last = nine_q ? BW'(DW) : BW'(DW - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; cnt_q <= '0; bidx_q <= '0; shreg_q <= '0;
         prev_q <= 1'b1; va_q <= 1'b0; vb_q <= 1'b0; nine_q <= 1'b0;
         done_q <= 1'b0; ferr_q <= 1'b0;
      end else if (clr) begin
         st_q <= ST_IDLE; cnt_q <= '0; bidx_q <= '0; shreg_q <= '0;
         prev_q <= 1'b1; va_q <= 1'b0; vb_q <= 1'b0; nine_q <= 1'b0;
         done_q <= 1'b0; ferr_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tick) begin
            prev_q <= rxd;
            cnt_q  <= (cnt_q == CW'(OVS - 1)) ? '0 : cnt_q + 1'b1;
            unique case (st_q)
               ST_IDLE: begin
                  cnt_q <= CW'(1);
                  if (prev_q && !rxd) begin
                     st_q    <= ST_START;
                     shreg_q <= '0;
                     nine_q  <= nine;
                  end
               end
               ST_START: begin
                  if (cnt_q == CW'(MID) && rxd) begin
                     st_q <= ST_IDLE;
                  end else if (cnt_q == CW'(OVS - 1)) begin
                     st_q   <= ST_DATA;
                     bidx_q <= '0;
                  end
               end
               ST_DATA: begin
                  if (cnt_q == CW'(MID - 1)) va_q <= rxd;
                  if (cnt_q == CW'(MID))     vb_q <= rxd;
                  if (cnt_q == CW'(MID + 1)) shreg_q[bidx_q] <= maj3(va_q, vb_q, rxd);
                  if (cnt_q == CW'(OVS - 1)) begin
                     if (bidx_q == last) st_q <= ST_STOP;
                     else                bidx_q <= bidx_q + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt_q == CW'(MID - 1)) va_q <= rxd;
                  if (cnt_q == CW'(MID))     vb_q <= rxd;
                  if (cnt_q == CW'(MID + 1)) begin
                     done_q <= 1'b1;
                     ferr_q <= ~maj3(va_q, vb_q, rxd);
                     st_q   <= ST_IDLE;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign done = done_q;
   assign word = shreg_q;
   assign ferr = ferr_q;
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int EW    = 10,
   parameter int DEPTH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [EW-1:0]              din,
   input  logic                       pop,
   output logic [EW-1:0]              dout,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   localparam int PW  = $clog2(DEPTH);
   localparam int CNW = $clog2(DEPTH + 1);

   logic [EW-1:0]  mem [DEPTH];
   logic [PW-1:0]  wp_q, rp_q;
   logic [CNW-1:0] cnt_q;
   logic           do_push, do_pop;

   assign full    = (cnt_q == CNW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      end else if (clr) begin
         wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= din;
   end

   assign dout  = mem[rp_q];
   assign count = cnt_q;
endmodule

// File: rtl/srx_top.sv
module srx_top #(
   parameter int DW          = 8,
   parameter int OVS         = 16,
   parameter int DEPTH       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick16,
   input  logic        rx_en,
   input  logic        nine_bit,
   input  logic        irq_en,
   input  logic        rxd,
   input  logic        rd_stb,
   output logic [DW:0] rd_data,
   output logic        rd_ferr,
   output logic        data_avail,
   output logic        irq,
   output logic        overrun
);
   localparam int EW  = DW + 2;
   localparam int CNW = $clog2(DEPTH + 1);

   if (OVS < 8 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("srx_top: OVS must be even and at least 8");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("srx_top: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("srx_top: DW must be at least 1");
   end

   logic           rxd_s, clr, fr_done, fr_ferr, push, pop, full, empty, ovr_q;
   logic [DW:0]    fr_word;
   logic [EW-1:0]  head;
   logic [CNW-1:0] fcount;

   assign clr = !rx_en;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
   );

   srx_frame #(.DW(DW), .OVS(OVS)) u_frame (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick16), .nine(nine_bit),
      .rxd(rxd_s), .done(fr_done), .word(fr_word), .ferr(fr_ferr)
   );

   assign push = fr_done && !ovr_q && !full;
   assign pop  = rd_stb && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ovr_q <= 1'b0;
      else if (clr)                  ovr_q <= 1'b0;
      else if (fr_done && full)      ovr_q <= 1'b1;
   end

   srx_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(push),
      .din({fr_ferr, fr_word}), .pop(pop), .dout(head),
      .count(fcount), .full(full), .empty(empty)
   );

   assign rd_data    = head[DW:0];
   assign rd_ferr    = head[DW+1];
   assign data_avail = !empty;
   assign irq        = data_avail && irq_en;
   assign overrun    = ovr_q;
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
   parameter int DEPTH = 2,
   parameter int CNW   = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           rx_en,
   input logic           rd_stb,
   input logic           irq,
   input logic           data_avail,
   input logic           overrun,
   input logic           push,
   input logic [CNW-1:0] fcount
);
   AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> data_avail);                                                   // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fcount <= CNW'(DEPTH));                                                // R5
   AST_READ_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && rd_stb && data_avail && !push) |=> (fcount == $past(fcount) - 1'b1)); // R5
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && overrun) |=> overrun);                                       // R7
   AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && overrun) |=> (fcount <= $past(fcount)));                     // R8
   AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!data_avail && !overrun));                                 // R9
endmodule

bind srx_top srx_chk #(.DEPTH(DEPTH), .CNW(CNW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_stb(rd_stb), .irq(irq),
   .data_avail(data_avail), .overrun(overrun), .push(push), .fcount(fcount)
);

// File: tb/sim_srx_top.sv
`timescale 1ns/100ps
module sim_srx_top;
   logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx_en = 1'b0;
   logic nine_bit = 1'b0, irq_en = 1'b0, rxd = 1'b1, rd_stb = 1'b0;
   logic [8:0] rd_data;
   logic rd_ferr, data_avail, irq, overrun;
   logic [1:0] tcnt = 2'd0;

   int errors = 0, checks = 0;
   bit finished = 1'b0;
   logic [9:0] mq[$];
   bit movr = 1'b0;

   srx_top u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en),
      .nine_bit(nine_bit), .irq_en(irq_en), .rxd(rxd), .rd_stb(rd_stb),
      .rd_data(rd_data), .rd_ferr(rd_ferr), .data_avail(data_avail),
      .irq(irq), .overrun(overrun)
   );

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      tcnt   <= tcnt + 2'd1;
      tick16 <= (tcnt == 2'd0);
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [9:0] exp_entry(input logic [8:0] d, input bit nine, input bit stopv);
      return {~stopv, nine ? d : {1'b0, d[7:0]}};
   endfunction

   task automatic send(input logic [8:0] d, input bit nine, input bit stopv);
      @(negedge clk);
      nine_bit = nine;
      rxd = 1'b0;
      repeat (64) @(negedge clk);
      for (int k = 0; k < (nine ? 9 : 8); k++) begin
         rxd = d[k];
         repeat (64) @(negedge clk);
      end
      rxd = stopv;
      repeat (64) @(negedge clk);
      rxd = 1'b1;
      repeat (32) @(negedge clk);
      if (rx_en) begin
         if (movr)                 ;
         else if (mq.size() == 2)  movr = 1'b1;
         else                      mq.push_back(exp_entry(d, nine, stopv));
      end
   endtask

   task automatic chk_state(input string tag);
      chk(data_avail == (mq.size() != 0), {tag, " data_avail"}, data_avail, mq.size() != 0);
      chk(overrun == movr, {tag, " overrun"}, overrun, movr);
      chk(irq == ((mq.size() != 0) && irq_en), {tag, " irq"}, irq, (mq.size() != 0) && irq_en);
   endtask

   task automatic rd_check(input string tag);
      if (mq.size() != 0) begin
         chk(rd_data == mq[0][8:0], {tag, " data"}, rd_data, mq[0][8:0]);
         chk(rd_ferr == mq[0][9], {tag, " ferr"}, rd_ferr, mq[0][9]);
         @(negedge clk) rd_stb = 1'b1;
         @(negedge clk) rd_stb = 1'b0;
         void'(mq.pop_front());
         chk(data_avail == (mq.size() != 0), {tag, " avail after pop"}, data_avail, mq.size() != 0);
      end
   endtask

   task automatic toggle_en(input string tag);
      @(negedge clk) rx_en = 1'b0;
      @(negedge clk);
      chk(!data_avail, {tag, " flushed"}, data_avail, 0);
      chk(!overrun, {tag, " overrun cleared"}, overrun, 0);
      rx_en = 1'b1;
      mq.delete();
      movr = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (10) @(negedge clk);
      chk(!data_avail && !irq && !overrun, "R6 reset state", {data_avail, irq, overrun}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!data_avail && !irq && !overrun, "R6 after reset", {data_avail, irq, overrun}, 0);
      rx_en = 1'b1; irq_en = 1'b1;
      repeat (20) @(negedge clk);

      // R3 8-bit, 9-bit and masked 9th bit
      send(9'h0A5, 1'b0, 1'b1); chk_state("R3 8bit"); rd_check("R3 8bit");
      send(9'h15A, 1'b1, 1'b1); chk_state("R3 9bit"); rd_check("R3 9bit");
      send(9'h1C3, 1'b0, 1'b1); rd_check("R3 mask bit8");

      // R4 framing error
      send(9'h03C, 1'b0, 1'b0); chk_state("R4"); rd_check("R4 ferr");

      // R5 per-entry flags across a pop
      send(9'h011, 1'b0, 1'b0);
      send(9'h122, 1'b1, 1'b1);
      chk_state("R5 two queued");
      rd_check("R5 head1");
      rd_check("R5 head2");

      // R6 interrupt gating
      send(9'h077, 1'b0, 1'b1);
      @(negedge clk) irq_en = 1'b0;
      @(negedge clk) chk(irq == 1'b0, "R6 irq masked", irq, 0);
      irq_en = 1'b1;
      @(negedge clk) chk(irq == 1'b1, "R6 irq enabled", irq, 1);
      rd_check("R6 drain");
      chk_state("R6 empty");

      // R7 overrun, R8 frozen
      send(9'h0A1, 1'b0, 1'b1);
      send(9'h0B2, 1'b0, 1'b0);
      send(9'h0C3, 1'b0, 1'b1);
      chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
      chk_state("R7 overrun");
      send(9'h0D4, 1'b0, 1'b1);
      rd_check("R7 kept1");
      rd_check("R7 kept2");
      send(9'h0E5, 1'b0, 1'b1);
      chk(!data_avail, "R8 no receive while overrun", data_avail, 0);
      chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);

      // R9 disable clears and flushes
      toggle_en("R9 clear overrun");
      send(9'h05A, 1'b0, 1'b1);
      chk_state("R9 receive after re-enable");
      toggle_en("R9 flush");

      // R1 disabled reception
      @(negedge clk) rx_en = 1'b0;
      send(9'h0F0, 1'b0, 1'b1);
      @(negedge clk) rx_en = 1'b1;
      repeat (40) @(negedge clk);
      chk(!data_avail, "R1 ignored while disabled", data_avail, 0);

      // R2 false start
      @(negedge clk) rxd = 1'b0;
      repeat (12) @(negedge clk);
      rxd = 1'b1;
      repeat (400) @(negedge clk);
      chk(!data_avail, "R2 false start", data_avail, 0);
      send(9'h099, 1'b0, 1'b1);
      rd_check("R2 valid after false start");

      // seeded random mix
      for (int i = 0; i < 40; i++) begin
         logic [8:0] d;
         bit nine, stopv;
         d     = 9'($urandom);
         nine  = 1'($urandom % 2);
         stopv = ($urandom % 4) != 0;
         send(d, nine, stopv);
         chk_state("R5 random");
         if ($urandom % 3 != 0) rd_check("R3 random");
         if (movr && ($urandom % 2 == 0)) toggle_en("R9 random");
      end
      while (mq.size() != 0) rd_check("R5 final drain");
      chk_state("R6 final");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule